// File: doc/BRIEF.md
# Mode-Gated Write-Through Cache with Line Locking

This block is a small cache placed between a processor core and a 32-bit memory bus. It stores 16 lines of 16 bytes (four 32-bit words per line, 256 bytes in total) and is fully associative. A two-bit mode input chooses which class of access may use it: data, instructions, both or neither. Every access is tagged as an instruction or a data access and may also carry an uncached flag that is produced by address translation. When the mode excludes the access, or the flag is set, the access goes straight to the bus.

Loads that miss fetch the whole line as four sequential bus reads. The core is stalled until the line is in place, and the word is then returned from the cache. Stores always go out on the bus. A store that hits also updates the cached copy, but a store that misses leaves the cache unchanged. A load can ask for its line to be pinned. Pinned lines are never replaced, and a single invalidate pulse empties the whole cache.

The core keeps its request signals stable until the block acknowledges the request. The block keeps its bus request and address stable until the bus acknowledges.

Top module: `cfg_wt_cache`

## Requirements
- R1: A load that takes part in caching and hits is acknowledged in the cycle it is first presented, returns the stored word and issues no bus operation.
- R2: A load that takes part in caching and misses, with a replaceable line available, issues exactly four bus reads at the line base plus 0, 4, 8 and 12, in that order. The requested word is then returned from the cache in the cycle after the last read completes.
- R3: cfg_mode bit 0 enables caching of data accesses and bit 1 enables caching of instruction accesses (00 none, 01 data, 10 instructions, 11 both). A load of a disabled class performs one bus read at its own address, never hits and allocates nothing.
- R4: A load or store with cpu_uncached set never hits, never allocates and never changes cached contents. A load performs a single bus read.
- R5: Every store performs exactly one bus write carrying its address and data, and is acknowledged when the bus completes it. A store that hits also replaces the cached word.
- R6: A store that misses allocates no line and issues no bus read.
- R7: The line replaced on a miss is the first unlocked line found when counting upward, with wrap-around, from a pointer. After each fill the pointer moves to the line after the replaced one.
- R8: A caching load with cpu_lock set locks the line it hits or fills. A locked line is never replaced. If all lines are locked, a miss is served by one bus read and allocates nothing.
- R9: A one-cycle pulse on inval_all makes every line invalid and unlocked, including lines that were locked. The replacement pointer is unchanged.
- R10: After reset, no line is valid or locked, the pointer is 0, and neither bus_req nor cpu_ack is asserted while no request is pending.
- R11: Once bus_req is asserted, it stays asserted with bus_addr and bus_we stable until a cycle with bus_ack high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Caching mode: bit 0 data, bit 1 instructions |
| inval_all | input | 1 | Invalidate every line and clear every lock |
| cpu_req | input | 1 | Core access pending |
| cpu_we | input | 1 | Access is a store |
| cpu_is_instr | input | 1 | Access is an instruction fetch |
| cpu_uncached | input | 1 | Access must bypass the cache |
| cpu_lock | input | 1 | Lock the line used by this load |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_ack | output | 1 | Access complete |
| cpu_rdata | output | 32 | Load data, valid with cpu_ack |
| bus_req | output | 1 | Bus operation pending |
| bus_we | output | 1 | Bus operation is a write |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus operation complete |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |

## Verification
Loads and stores are run under each of the four modes, with instruction and data tags and with the uncached flag. A bus operation that is missing or unexpected therefore shows whether the hit, fill, bypass or write-through path was taken. The bench writes to a cached word through the uncached path and then reads it back through the cache, which separates a true bypass from a cache that was quietly updated. Sixteen line fills with a scattered lock pattern, followed by further misses, expose the order in which victims are chosen. Locking every line and then invalidating separates a full cache that refuses to allocate from one where invalidation has cleared the locks. Bus latencies of zero, one and two wait cycles test whether requests are held stable and whether the fill counter advances correctly.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;

  // Caching mode: bit 0 admits data accesses, bit 1 admits instruction fetches
  typedef enum logic [1:0] {
    CM_OFF   = 2'b00,
    CM_DATA  = 2'b01,
    CM_INSTR = 2'b10,
    CM_BOTH  = 2'b11
  } cmode_e;

  // Sequencer states
  typedef enum logic [1:0] {
    S_IDLE = 2'b00,
    S_FILL = 2'b01,
    S_RD   = 2'b10,
    S_WR   = 2'b11
  } cstate_e;

endpackage

// File: rtl/cfgc_tag_store.sv
module cfgc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 28,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             vic_ok,
  output logic [IDX_W-1:0] vic_idx,
  input  logic             inval,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             lock_en,
  input  logic [IDX_W-1:0] lock_idx
);

  logic [LINES-1:0] valid_q, valid_d;
  logic [LINES-1:0] lock_q, lock_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] match;
  logic [IDX_W-1:0] cand;

  // One comparator per line
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  // First unlocked line at or after the pointer, with wrap-around
  always_comb begin
    vic_ok  = 1'b0;
    vic_idx = ptr_q;
    cand    = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      cand = ptr_q + IDX_W'(k);
      if (!lock_q[cand]) begin
        vic_ok  = 1'b1;
        vic_idx = cand;
      end
    end
  end

  always_comb begin
    valid_d = valid_q;
    lock_d  = lock_q;
    ptr_d   = ptr_q;
    if (alloc_en) begin
      valid_d[alloc_idx] = 1'b1;
      ptr_d              = alloc_idx + IDX_W'(1);
    end
    if (lock_en) lock_d[lock_idx] = 1'b1;
    if (inval) begin
      valid_d = '0;
      lock_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      lock_q  <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      lock_q  <= lock_d;
      ptr_q   <= ptr_d;
    end
  end

  // Tag array: written only on allocation, no reset needed
  always_ff @(posedge clk) begin
    if (alloc_en) tag_q[alloc_idx] <= alloc_tag;
  end

endmodule

// File: rtl/cfgc_data_store.sv
module cfgc_data_store #(
  parameter int LINES  = 16,
  parameter int WPL    = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WORD_W = $clog2(WPL),
  localparam int DEPTH  = LINES * WPL
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_line,
  input  logic [WORD_W-1:0] w_word,
  input  logic [DATA_W-1:0] w_data,
  input  logic [IDX_W-1:0]  r_line,
  input  logic [WORD_W-1:0] r_word,
  output logic [DATA_W-1:0] r_data
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[{w_line, w_word}] <= w_data;
  end

  assign r_data = mem_q[{r_line, r_word}];

endmodule

// File: rtl/cfg_wt_cache.sv
module cfg_wt_cache
  import cfgc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 16,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int WPL    = LINE_BYTES / (DATA_W / 8),
  localparam int WORD_W = $clog2(WPL),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - WORD_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              inval_all,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_is_instr,
  input  logic              cpu_uncached,
  input  logic              cpu_lock,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);

  cstate_e           st_q, st_d;
  logic [WORD_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0]  vic_q, vic_d;

  logic [TAG_W-1:0]  req_tag;
  logic [WORD_W-1:0] req_word;
  logic              class_en, takes_part, cached_hit;
  logic              tg_hit, tg_vic_ok;
  logic [IDX_W-1:0]  tg_hit_idx, tg_vic_idx;
  logic              alloc_en, lock_en;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_line;
  logic [WORD_W-1:0] ram_word;
  logic [DATA_W-1:0] ram_wdata, rd_data;

  assign req_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_word   = cpu_addr[BYTE_W +: WORD_W];
  assign class_en   = cpu_is_instr ? cfg_mode[1] : cfg_mode[0];
  assign takes_part = class_en && !cpu_uncached;
  assign cached_hit = takes_part && tg_hit;

  cfgc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_tag    (req_tag),
    .hit       (tg_hit),
    .hit_idx   (tg_hit_idx),
    .vic_ok    (tg_vic_ok),
    .vic_idx   (tg_vic_idx),
    .inval     (inval_all),
    .alloc_en  (alloc_en),
    .alloc_idx (vic_q),
    .alloc_tag (req_tag),
    .lock_en   (lock_en),
    .lock_idx  (tg_hit_idx)
  );

  cfgc_data_store #(.LINES(LINES), .WPL(WPL), .DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .we     (ram_we),
    .w_line (ram_line),
    .w_word (ram_word),
    .w_data (ram_wdata),
    .r_line (tg_hit_idx),
    .r_word (req_word),
    .r_data (rd_data)
  );

  // Next-state and output logic
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    vic_d     = vic_q;
    cpu_ack   = 1'b0;
    cpu_rdata = rd_data;
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = cpu_addr;
    bus_wdata = cpu_wdata;
    ram_we    = 1'b0;
    ram_line  = tg_hit_idx;
    ram_word  = req_word;
    ram_wdata = cpu_wdata;
    alloc_en  = 1'b0;
    lock_en   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (cpu_req) begin
          if (!cpu_we) begin
            if (cached_hit) begin
              cpu_ack = 1'b1;
              lock_en = cpu_lock;
            end else if (takes_part && tg_vic_ok) begin
              st_d  = S_FILL;
              cnt_d = '0;
              vic_d = tg_vic_idx;
            end else begin
              st_d = S_RD;
            end
          end else begin
            ram_we = cached_hit;
            st_d   = S_WR;
          end
        end
      end
      S_FILL: begin
        bus_req   = 1'b1;
        bus_addr  = {req_tag, cnt_q, {BYTE_W{1'b0}}};
        ram_line  = vic_q;
        ram_word  = cnt_q;
        ram_wdata = bus_rdata;
        if (bus_ack) begin
          ram_we = 1'b1;
          cnt_d  = cnt_q + WORD_W'(1);
          if (cnt_q == WORD_W'(WPL - 1)) begin
            alloc_en = 1'b1;
            st_d     = S_IDLE;
          end
        end
      end
      S_RD: begin
        bus_req = 1'b1;
        if (bus_ack) begin
          cpu_ack   = 1'b1;
          cpu_rdata = bus_rdata;
          st_d      = S_IDLE;
        end
      end
      S_WR: begin
        bus_req = 1'b1;
        bus_we  = 1'b1;
        if (bus_ack) begin
          cpu_ack = 1'b1;
          st_d    = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      vic_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      vic_q <= vic_d;
    end
  end

endmodule

// File: rtl/cfgc_chk.sv
module cfgc_chk #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 2,
  parameter int WORD_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_mode,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_uncached,
  input logic              cpu_ack,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack
);

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R2
  fill_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_we && !cpu_ack &&
     bus_addr[BYTE_W +: WORD_W] != {WORD_W{1'b1}})
    |=> (bus_req && !bus_we &&
         bus_addr == $past(bus_addr) + (ADDR_W'(1) << BYTE_W)));

  // R6
  no_wr_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we) |-> !(bus_req && !bus_we));

  // R4
  unc_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_uncached && !cpu_we && cpu_ack) |-> bus_ack);

  // R3
  off_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cfg_mode == 2'b00 && cpu_ack) |-> bus_ack);

  // R1
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !bus_ack) |-> !bus_req);

  // R5
  wr_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && cpu_ack) |-> (bus_we && bus_ack));

endmodule

bind cfg_wt_cache cfgc_chk #(
  .ADDR_W (ADDR_W),
  .BYTE_W (BYTE_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_mode     (cfg_mode),
  .cpu_req      (cpu_req),
  .cpu_we       (cpu_we),
  .cpu_uncached (cpu_uncached),
  .cpu_ack      (cpu_ack),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_ack      (bus_ack)
);

// File: tb/tb_cfg_wt_cache.sv
`timescale 1ns/1ps
module tb_cfg_wt_cache;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b11;
  logic        inval_all = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_is_instr = 1'b0;
  logic        cpu_uncached = 1'b0, cpu_lock = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  cfg_wt_cache dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(mode), .inval_all(inval_all),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_is_instr(cpu_is_instr),
    .cpu_uncached(cpu_uncached), .cpu_lock(cpu_lock), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int fails  = 0;
  string cur_rq = "R10";

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Behavioural environment and reference model
  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] mrd(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return (a * 32'h0000_9E37) ^ 32'h5A5A_0000;
  endfunction

  typedef struct { logic we; logic [31:0] addr; logic [31:0] data; } bop_t;
  bop_t expq[$];

  logic [27:0] m_tag [16];
  bit          m_val [16];
  bit          m_lck [16];
  logic [31:0] m_dat [16][4];
  int          m_ptr = 0;
  int          lat = 0;
  int          waitc = 0;

  // Bus responder, compares every bus operation on the clock it completes
  always @(negedge clk) begin
    bop_t op;
    bus_ack = 1'b0;
    if (rst_n && bus_req) begin
      if (waitc < lat) waitc++;
      else begin
        waitc = 0;
        if (expq.size() == 0) chk(1'b0, cur_rq, "unexpected bus op", bus_addr, 32'h0);
        else begin
          op = expq.pop_front();
          chk(op.we == bus_we && op.addr == bus_addr && (!op.we || op.data == bus_wdata),
              cur_rq, "bus op addr", bus_addr, op.addr);
        end
        if (bus_we) mem[bus_addr] = bus_wdata;
        else bus_rdata = mrd(bus_addr);
        bus_ack = 1'b1;
      end
    end
  end

  task automatic acc(bit we, bit ins, bit unc, bit lk, logic [31:0] a,
                     logic [31:0] wd, string rq);
    bit part, exp_hit;
    int hi, v, w, n;
    logic [27:0] ln;
    logic [31:0] exp_rd;
    cur_rq = rq;
    part = !unc && (ins ? mode[1] : mode[0]);
    ln = a[31:4];
    w = int'(a[3:2]);
    hi = -1;
    exp_hit = 0;
    exp_rd = '0;
    for (int i = 0; i < 16; i++) if (part && m_val[i] && m_tag[i] == ln) hi = i;
    if (!we) begin
      if (hi >= 0) begin
        exp_hit = 1;
        exp_rd = m_dat[hi][w];
        if (lk) m_lck[hi] = 1;
      end else begin
        v = -1;
        if (part) for (int k = 0; k < 16; k++)
          if (v < 0 && !m_lck[(m_ptr + k) % 16]) v = (m_ptr + k) % 16;
        if (v >= 0) begin
          for (int j = 0; j < 4; j++) begin
            expq.push_back('{we: 1'b0, addr: {ln, 4'(j * 4)}, data: 32'h0});
            m_dat[v][j] = mrd({ln, 4'(j * 4)});
          end
          m_val[v] = 1;
          m_tag[v] = ln;
          m_ptr = (v + 1) % 16;
          exp_rd = m_dat[v][w];
          if (lk) m_lck[v] = 1;
        end else begin
          expq.push_back('{we: 1'b0, addr: a, data: 32'h0});
          exp_rd = mrd(a);
        end
      end
    end else begin
      expq.push_back('{we: 1'b1, addr: a, data: wd});
      if (hi >= 0) m_dat[hi][w] = wd;
    end
    cpu_req = 1; cpu_we = we; cpu_is_instr = ins; cpu_uncached = unc;
    cpu_lock = lk; cpu_addr = a; cpu_wdata = wd;
    n = 0;
    do begin
      @(negedge clk); #1;
      n++;
    end while (!cpu_ack && n < 200);
    chk(cpu_ack, rq, "ack timeout", 32'(n), 32'd200);
    if (exp_hit) chk(n == 1, rq, "hit ack cycle (R1)", 32'(n), 32'd1);
    if (!we) chk(cpu_rdata == exp_rd, rq, "load data", cpu_rdata, exp_rd);
    @(posedge clk); #1;
    cpu_req = 0;
    chk(expq.size() == 0, rq, "bus ops left", 32'(expq.size()), 32'd0);
    expq.delete();
  endtask

  task automatic invalidate();
    inval_all = 1;
    @(posedge clk); #1;
    inval_all = 0;
    for (int i = 0; i < 16; i++) begin m_val[i] = 0; m_lck[i] = 0; end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_val[i] = 0; m_lck[i] = 0; m_tag[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R10 reset state
    chk(!bus_req, "R10", "bus_req after reset", 32'(bus_req), 32'd0);
    chk(!cpu_ack, "R10", "cpu_ack after reset", 32'(cpu_ack), 32'd0);
    @(posedge clk); #1;

    // R2 fills, R1 hits, mode both
    lat = 0; mode = 2'b11;
    acc(0, 0, 0, 0, 32'h0000_0100, 0, "R2");
    acc(0, 0, 0, 0, 32'h0000_0104, 0, "R1");
    acc(0, 1, 0, 0, 32'h0000_0208, 0, "R2");
    acc(0, 0, 0, 0, 32'h0000_010C, 0, "R1");

    // R5 write-through, R6 no-write-allocate, R11 wait states
    lat = 1;
    acc(1, 0, 0, 0, 32'h0000_0104, 32'hDEAD_BEEF, "R5");
    acc(0, 0, 0, 0, 32'h0000_0104, 0, "R5");
    acc(1, 0, 0, 0, 32'h0000_3000, 32'h1234_5678, "R6");
    acc(0, 0, 0, 0, 32'h0000_3000, 0, "R6");
    acc(1, 0, 0, 0, 32'h0000_3008, 32'h0BAD_F00D, "R11");

    // R4 uncached bypass: stale cached copy proves no hit and no update
    acc(0, 0, 1, 0, 32'h0000_0100, 0, "R4");
    acc(1, 0, 1, 0, 32'h0000_0108, 32'h1111_2222, "R4");
    acc(0, 0, 0, 0, 32'h0000_0108, 0, "R4");

    // R3 mode gating
    mode = 2'b01;
    acc(0, 1, 0, 0, 32'h0000_0200, 0, "R3");
    acc(0, 0, 0, 0, 32'h0000_0104, 0, "R3");
    acc(0, 0, 0, 0, 32'h0000_4000, 0, "R3");
    mode = 2'b10;
    acc(0, 0, 0, 0, 32'h0000_0104, 0, "R3");
    acc(0, 1, 0, 0, 32'h0000_0204, 0, "R3");
    acc(0, 1, 0, 0, 32'h0000_5004, 0, "R3");
    mode = 2'b00;
    acc(0, 0, 0, 0, 32'h0000_0100, 0, "R3");
    acc(0, 1, 0, 0, 32'h0000_0200, 0, "R3");

    // R9 invalidate, R7 replacement order, R8 locking
    lat = 2; mode = 2'b11;
    invalidate();
    acc(0, 0, 0, 0, 32'h0000_0100, 0, "R9");
    for (int k = 0; k < 16; k++)
      acc(0, 0, 0, (k % 5 == 0), 32'h0000_8000 + 32'(k * 16), 0, "R7");
    acc(0, 0, 0, 0, 32'h0000_9000, 0, "R7");
    acc(0, 0, 0, 0, 32'h0000_9010, 0, "R7");
    for (int k = 0; k < 16; k++)
      acc(0, 0, 0, 0, 32'h0000_8000 + 32'(k * 16), 0, "R8");
    for (int i = 0; i < 16; i++)
      acc(0, 0, 0, 1, {m_tag[i], 4'h4}, 0, "R8");
    acc(0, 0, 0, 0, 32'h0000_A000, 0, "R8");
    acc(0, 0, 0, 0, 32'h0000_A000, 0, "R8");
    acc(0, 0, 0, 0, {m_tag[3], 4'h8}, 0, "R8");
    invalidate();
    acc(0, 0, 0, 0, 32'h0000_A000, 0, "R9");
    acc(0, 0, 0, 0, 32'h0000_A004, 0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule